// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one character into one asynchronous serial frame on a single TX line. A start strobe begins each frame. A small set of line-control inputs sets the shape of the frame: the number of data bits (five to eight), the stop length (one, one and a half, or two bits) and the parity mode (none, odd, even, forced one, forced zero, or a bit taken from the caller's data). The data word is nine bits wide so that the caller can supply its own parity bit in the top position.

Bit timing comes from outside the block. A one-cycle `bitTick` from a baud generator marks each bit boundary. A 16x oversample tick `ovsTick` times the half-length stop period that only five-bit frames use. The block samples the data and all line-control inputs when it accepts a start and holds them for the whole frame. `busy` stays high from acceptance until the last stop period ends. `done` then pulses for one cycle.

Top module: `uartFrameTx`

## Requirements
- R1: After reset and at every other time that `busy` is low, `txOut` is 1, `busy` is 0 and `done` is 0 except for its single completion pulse.
- R2: A `startIn` pulse while idle raises `busy` in the next cycle. The start bit (`txOut`=0) begins at the first `bitTick` after acceptance. Every bit of the frame then lasts from one `bitTick` to the next.
- R3: `wordSel` encodings 00, 01, 10 and 11 send 5, 6, 7 and 8 data bits. Data bits go out least significant bit first, taken from `dataIn[0]` upward.
- R4: With `stopLong`=0 the frame ends with one stop bit (`txOut`=1) of one bit period.
- R5: With `stopLong`=1 and `wordSel` of 01, 10 or 11, the stop level lasts two bit periods.
- R6: With `stopLong`=1 and `wordSel`=00, the stop level lasts 24 `ovsTick` pulses, counted after the `bitTick` that began it.
- R7: With `parEnable`=0, no parity bit is sent, and `parEven`, `parStick` and `parFromData` have no effect.
- R8: With `parEnable`=1 and `parFromData`, `parStick` and `parEven` all 0, the parity bit makes the count of ones over the data bits and the parity bit odd.
- R9: With `parEnable`=1, `parFromData`=0, `parStick`=0 and `parEven`=1, the parity bit makes that count even.
- R10: With `parEnable`=1, `parFromData`=0 and `parStick`=1, the parity bit is 1 when `parEven`=0 and 0 when `parEven`=1, whatever the data.
- R11: With `parEnable`=1 and `parFromData`=1, the parity bit equals `dataIn[8]`, whatever `parStick` and `parEven` are.
- R12: `done` is high for exactly one cycle, in the cycle after the edge that ends the stop period. `busy` falls at that same edge.
- R13: Data and line control are captured when a start is accepted. Changes to them, and `startIn` pulses while `busy` is high, do not alter the frame and do not start another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Request to send one frame |
| dataIn | input | 9 | Data bits [7:0]; bit 8 is the supplied parity bit |
| wordSel | input | 2 | Data length select: 00=5, 01=6, 10=7, 11=8 bits |
| stopLong | input | 1 | 0: one stop bit; 1: 1.5 (5-bit words) or 2 stop bits |
| parEnable | input | 1 | Parity bit present |
| parEven | input | 1 | Even parity select; value selector in forced mode |
| parStick | input | 1 | Forced parity value |
| parFromData | input | 1 | Parity bit taken from `dataIn[8]` |
| bitTick | input | 1 | One-cycle pulse per bit period |
| ovsTick | input | 1 | One-cycle pulse at 16 times the bit rate |
| txOut | output | 1 | Serial line, idle high |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when a frame completes |

## Verification
Every output is registered. `busy` rises one cycle after the start pulse. Each line level changes at the clock edge that samples a `bitTick`. After the last stop tick, `done` rises and `busy` falls at the same edge. The bench drives inputs and reads outputs on falling edges. It samples each bit half a bit period after the start bit's falling edge, so no sample lands on a line change. It measures the frame length as the number of rising edges between the start bit's fall and the first falling edge that sees `done`. The expected length is 32 cycles per start, data and parity bit, plus 32, 48 or 64 cycles for the stop period. After that it looks one cycle later to confirm that `done` has dropped.

// File: rtl/uartTxPkg.sv
package uartTxPkg;

  typedef struct packed {
    logic [1:0] wordSel;
    logic       stopLong;
    logic       parEnable;
    logic       parEven;
    logic       parStick;
    logic       parFromData;
  } lineCfgT;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // capture data and line control
    logic sendLow;  // drive the start level
    logic sendData; // drive the next data bit and shift
    logic sendPar;  // drive the parity bit
    logic sendHigh; // drive the stop / idle level
  } txStrobesT;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_START, ST_DATA, ST_PAR, ST_STOP
  } txStateT;

endpackage

// File: rtl/uartTxDatapath.sv
module uartTxDatapath
  import uartTxPkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobesT         strb,
  input  logic [DATA_W-1:0] dataIn,
  input  lineCfgT           cfgIn,
  output lineCfgT           cfgQ,
  output logic              txOut
);

  localparam int MAX_WORD = DATA_W - 1;
  localparam int LEN_W    = $clog2(MAX_WORD + 1);

  logic [MAX_WORD-1:0] shReg;
  logic [MAX_WORD-1:0] wordMask;
  logic [MAX_WORD-1:0] maskedData;
  logic [LEN_W-1:0]    wordBits;
  logic                parBit;
  logic                parNext;
  logic                txReg;

  assign wordBits = LEN_W'(5) + LEN_W'(cfgIn.wordSel);

  // mask off the data bits above the selected word length
  generate
    for (genvar i = 0; i < MAX_WORD; i++) begin : gMask
      assign wordMask[i] = (i < int'(wordBits));
    end
  endgenerate

  assign maskedData = dataIn[MAX_WORD-1:0] & wordMask;

  // parity select: supplied bit first, then forced value, then computed value
  always_comb begin
    if (cfgIn.parFromData)   parNext = dataIn[DATA_W-1];
    else if (cfgIn.parStick) parNext = ~cfgIn.parEven;
    else if (cfgIn.parEven)  parNext = ^maskedData;
    else                     parNext = ~(^maskedData);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      parBit <= 1'b0;
      cfgQ   <= '0;
    end else if (strb.load) begin
      shReg  <= maskedData;
      parBit <= parNext;
      cfgQ   <= cfgIn;
    end else if (strb.sendData) begin
      shReg  <= shReg >> 1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              txReg <= 1'b1;
    else if (strb.sendLow)  txReg <= 1'b0;
    else if (strb.sendData) txReg <= shReg[0];
    else if (strb.sendPar)  txReg <= parBit;
    else if (strb.sendHigh) txReg <= 1'b1;
  end

  assign txOut = txReg;

  // R13: captured line control only changes when a new frame is loaded
  a_r13_cfg_held : assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(cfgQ));

  // R2: the start level is entered from the high level only
  a_r2_low_from_high : assert property (@(posedge clk) disable iff (!rstN)
    strb.sendLow |=> ($past(txReg) == 1'b1) && !txReg);

endmodule

// File: rtl/uartTxControl.sv
module uartTxControl
  import uartTxPkg::*;
#(
  parameter int DATA_W   = 9,
  parameter int OVS_RATE = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startIn,
  input  logic      bitTick,
  input  logic      ovsTick,
  input  lineCfgT   cfgQ,
  output txStrobesT strb,
  output logic      busy,
  output logic      done
);

  localparam int MAX_WORD = DATA_W - 1;
  localparam int CNT_W    = $clog2(MAX_WORD + 1);
  localparam int HALF_OVS = (OVS_RATE * 3) / 2;
  localparam int OVS_W    = $clog2(HALF_OVS + 1);

  txStateT          state, stateNext;
  logic [CNT_W-1:0] sentCnt, sentNext;
  logic [OVS_W-1:0] ovsCnt, ovsNext;
  logic             stopCnt, stopNext;
  logic             doneNext;
  logic [CNT_W-1:0] wordBits;
  logic             halfStop;

  assign wordBits = CNT_W'(5) + CNT_W'(cfgQ.wordSel);
  assign halfStop = cfgQ.stopLong && (cfgQ.wordSel == 2'b00);

  always_comb begin
    stateNext = state;
    sentNext  = sentCnt;
    ovsNext   = ovsCnt;
    stopNext  = stopCnt;
    doneNext  = 1'b0;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (startIn) begin
          strb.load = 1'b1;
          stateNext = ST_ARM;
        end
      end
      ST_ARM: begin
        if (bitTick) begin
          strb.sendLow = 1'b1;
          stateNext    = ST_START;
        end
      end
      ST_START: begin
        if (bitTick) begin
          strb.sendData = 1'b1;
          sentNext      = CNT_W'(1);
          stateNext     = ST_DATA;
        end
      end
      ST_DATA: begin
        if (bitTick) begin
          if (sentCnt != wordBits) begin
            strb.sendData = 1'b1;
            sentNext      = sentCnt + CNT_W'(1);
          end else if (cfgQ.parEnable) begin
            strb.sendPar = 1'b1;
            stateNext    = ST_PAR;
          end else begin
            strb.sendHigh = 1'b1;
            stopNext      = 1'b0;
            ovsNext       = '0;
            stateNext     = ST_STOP;
          end
        end
      end
      ST_PAR: begin
        if (bitTick) begin
          strb.sendHigh = 1'b1;
          stopNext      = 1'b0;
          ovsNext       = '0;
          stateNext     = ST_STOP;
        end
      end
      ST_STOP: begin
        if (halfStop) begin
          if (ovsTick) begin
            if (ovsCnt == OVS_W'(HALF_OVS - 1)) begin
              stateNext = ST_IDLE;
              doneNext  = 1'b1;
            end else begin
              ovsNext = ovsCnt + OVS_W'(1);
            end
          end
        end else if (bitTick) begin
          if (cfgQ.stopLong && !stopCnt) begin
            stopNext = 1'b1;
          end else begin
            stateNext = ST_IDLE;
            doneNext  = 1'b1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      sentCnt <= '0;
      ovsCnt  <= '0;
      stopCnt <= 1'b0;
      done    <= 1'b0;
    end else begin
      state   <= stateNext;
      sentCnt <= sentNext;
      ovsCnt  <= ovsNext;
      stopCnt <= stopNext;
      done    <= doneNext;
    end
  end

  assign busy = (state != ST_IDLE);

  // R12: completion pulse lasts one cycle
  a_r12_done_single : assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R12: busy drops exactly when done appears
  a_r12_busy_fall : assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R2: a frame only begins after a start request
  a_r2_busy_rise : assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startIn));

  // R3: the data bit counter never passes the selected word length
  a_r3_count_bound : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) |-> (sentCnt <= wordBits));

  // R6: the half-bit counter stays within its window
  a_r6_ovs_bound : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP) |-> (ovsCnt < OVS_W'(HALF_OVS)));

endmodule

// File: rtl/uartFrameTx.sv
module uartFrameTx
  import uartTxPkg::*;
#(
  parameter int DATA_W   = 9,
  parameter int OVS_RATE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [1:0]        wordSel,
  input  logic              stopLong,
  input  logic              parEnable,
  input  logic              parEven,
  input  logic              parStick,
  input  logic              parFromData,
  input  logic              bitTick,
  input  logic              ovsTick,
  output logic              txOut,
  output logic              busy,
  output logic              done
);

  lineCfgT   cfgIn;
  lineCfgT   cfgQ;
  txStrobesT strb;

  assign cfgIn = '{wordSel:     wordSel,
                   stopLong:    stopLong,
                   parEnable:   parEnable,
                   parEven:     parEven,
                   parStick:    parStick,
                   parFromData: parFromData};

  uartTxControl #(.DATA_W(DATA_W), .OVS_RATE(OVS_RATE)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .bitTick (bitTick),
    .ovsTick (ovsTick),
    .cfgQ    (cfgQ),
    .strb    (strb),
    .busy    (busy),
    .done    (done)
  );

  uartTxDatapath #(.DATA_W(DATA_W)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .dataIn (dataIn),
    .cfgIn  (cfgIn),
    .cfgQ   (cfgQ),
    .txOut  (txOut)
  );

  // R1: line rests high whenever no frame is in progress
  a_r1_idle_high : assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txOut);

  // R1: no completion pulse while a frame is running
  a_r1_done_quiet : assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);

endmodule

// File: tb/tb_uartFrameTx.sv
`timescale 1ns/1ps
module tb_uartFrameTx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startIn = 1'b0;
  logic [8:0] dataIn = '0;
  logic [1:0] wordSel = '0;
  logic       stopLong = 1'b0;
  logic       parEnable = 1'b0;
  logic       parEven = 1'b0;
  logic       parStick = 1'b0;
  logic       parFromData = 1'b0;
  logic       bitTick = 1'b0;
  logic       ovsTick = 1'b0;
  logic       txOut, busy, done;

  int total = 0;
  int bad = 0;
  int cycNum = 0;
  int tickCnt = 0;

  always #4 clk = ~clk;

  uartFrameTx dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .dataIn(dataIn),
    .wordSel(wordSel), .stopLong(stopLong), .parEnable(parEnable),
    .parEven(parEven), .parStick(parStick), .parFromData(parFromData),
    .bitTick(bitTick), .ovsTick(ovsTick),
    .txOut(txOut), .busy(busy), .done(done)
  );

  always @(posedge clk) cycNum <= cycNum + 1;

  // bit period 32 cycles, oversample tick every 2 cycles
  always @(negedge clk) begin
    tickCnt <= (tickCnt + 1) % 32;
    bitTick <= (((tickCnt + 1) % 32) == 0);
    ovsTick <= (((tickCnt + 1) % 2) == 0);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic expParity(input logic [8:0] d, input logic [1:0] wl,
                                     input logic ev, input logic st, input logic ps);
    logic ones = 1'b0;
    for (int i = 0; i < 5 + wl; i++) ones ^= d[i];
    if (ps) return d[8];
    if (st) return ~ev;
    return ev ? ones : ~ones;
  endfunction

  task automatic runFrame(input logic [8:0] d, input logic [1:0] wl, input logic sl,
                          input logic pe, input logic ev, input logic st, input logic ps,
                          input bit disturb, input string req);
    logic expBits[12];
    int   nb, w, t0, guard, stopCyc;
    w  = 5 + wl;
    nb = 1 + w + (pe ? 1 : 0);
    expBits[0] = 1'b0;
    for (int i = 0; i < w; i++) expBits[1 + i] = d[i];
    if (pe) expBits[1 + w] = expParity(d, wl, ev, st, ps);
    expBits[nb] = 1'b1;
    stopCyc = !sl ? 32 : (wl == 2'b00 ? 48 : 64);

    @(negedge clk);
    dataIn = d; wordSel = wl; stopLong = sl; parEnable = pe;
    parEven = ev; parStick = st; parFromData = ps; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    check(busy === 1'b1, {"R2 busy after start ", req}, busy, 1);
    guard = 0;
    while (txOut === 1'b1 && guard < 200) begin @(negedge clk); guard++; end
    t0 = cycNum;
    repeat (15) @(negedge clk);
    check(txOut === expBits[0], {"R2 start bit ", req}, txOut, expBits[0]);
    for (int i = 1; i <= nb; i++) begin
      if (disturb && i == 1) begin
        startIn = 1'b1; dataIn = ~d; wordSel = ~wl; stopLong = ~sl;
        parEnable = ~pe; parEven = ~ev; parStick = ~st; parFromData = ~ps;
        @(negedge clk);
        startIn = 1'b0;
        repeat (31) @(negedge clk);
      end else begin
        repeat (32) @(negedge clk);
      end
      check(txOut === expBits[i], $sformatf("%s bit %0d", req, i), txOut, expBits[i]);
      check(busy === 1'b1, {"R13 busy in frame ", req}, busy, 1);
    end
    guard = 0;
    while (done !== 1'b1 && guard < 400) begin @(negedge clk); guard++; end
    check(cycNum - t0 == 32 * nb + stopCyc, {"R12 frame length ", req},
          cycNum - t0, 32 * nb + stopCyc);
    check(busy === 1'b0, {"R12 busy low at done ", req}, busy, 0);
    @(negedge clk);
    check(done === 1'b0, {"R12 done one cycle ", req}, done, 0);
    if (disturb) begin
      int seenBusy = 0;
      repeat (80) begin
        @(negedge clk);
        if (busy !== 1'b0 || txOut !== 1'b1) seenBusy++;
      end
      check(seenBusy == 0, {"R13 no second frame ", req}, seenBusy, 0);
    end
    startIn = 1'b0;
  endtask

  task automatic testReset();
    check(txOut === 1'b1, "R1 reset txOut", txOut, 1);
    check(busy === 1'b0, "R1 reset busy", busy, 0);
    check(done === 1'b0, "R1 reset done", done, 0);
  endtask

  task automatic testWordLengths();
    runFrame(9'h0B5, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 R4 five bits");
    runFrame(9'h0A6, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 six bits");
    runFrame(9'h13C, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 seven bits");
    runFrame(9'h0C9, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 eight bits");
  endtask

  task automatic testStops();
    runFrame(9'h015, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 half stop");
    runFrame(9'h02A, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 two stop six");
    runFrame(9'h0F0, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 two stop eight");
  endtask

  task automatic testParity();
    runFrame(9'h0E3, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R7 parity off");
    runFrame(9'h0E3, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8 odd");
    runFrame(9'h0E1, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8 odd other");
    runFrame(9'h0E3, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9 even");
    runFrame(9'h1F7, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9 even five");
    runFrame(9'h000, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R10 forced one");
    runFrame(9'h07F, 2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R10 forced zero");
    runFrame(9'h100, 2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R11 from data one");
    runFrame(9'h0FF, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R11 from data zero");
  endtask

  task automatic testIgnoreBusy();
    runFrame(9'h05A, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R13 changes ignored");
    runFrame(9'h013, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R13 half stop held");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testWordLengths();
    testStops();
    testParity();
    testIgnoreBusy();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule